// File: doc/BRIEF.md
# Shared-Line Bus Handover Arbiter

This block hands the local bus to other bus masters over a small set of bidirectional, active-low request/grant lines, one line per external master. A handover uses only that master's line and consists of three one-clock low pulses. The master pulses to ask for the bus. The arbiter pulses back to grant it. The master pulses again when it gives the bus back. The arbiter watches each line. It drives a line low only for the single clock of a grant, through an open-drain style enable, and it lets the line float at all other times.

The arbiter does not run bus cycles itself. A separate bus cycle sequencer reports the current bus phase. It also reports whether the running transfer is the low half of a split word at an odd address, whether it is the first of a pair of interrupt-acknowledge transfers, and whether a locked instruction is in progress. From these inputs the arbiter decides when the bus may be let go. While an external master owns the bus, the arbiter raises a float command for the local bus interface. After every handover it leaves one dead clock before it will grant again. A lower line index has the higher priority.

Top module: `rg_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it is released, no line drive enable is set, the float command is low and the owner vector is zero.
- R2: A request is a line sampled low at a clock edge, provided the line was high or driven by the arbiter at the previous edge and is not driven by the arbiter now. When the bus is idle (phase code 0) and no lock is active, the grant drive enable for that line is set in the clock that follows the edge where the request was sampled.
- R3: The float command rises in the clock after a grant and stays high while the owner vector marks the granted line. It falls right after the edge where the owner's release pulse is sampled.
- R4: In the clock after the float command falls, no grant is driven, even with a request pending. A pending request may be granted in the clock after that.
- R5: When several lines hold pending requests, the line with the lowest index is granted first. The others stay pending and are served after the handover has ended and its dead clock has passed.
- R6: While a bus transfer is running (phase codes 1=T1, 2=T2, 3=T3, 4=wait, 5=T4), a grant is driven only in a T4 clock.
- R7: A request sampled during a T3 or wait clock is not granted in the T4 of that same transfer. It becomes eligible after that T4 has passed.
- R8: No grant is driven in a T4 clock while the odd-address low-half flag or the first-interrupt-acknowledge flag is set. The request stays pending.
- R9: No grant is driven while the lock input is high. The request stays pending.
- R10: At most one drive enable is set at a time. Each drive enable lasts exactly one clock, and none is set while the float command is high.
- R11: Extra request pulses from a line that already has a request pending add nothing. That line receives exactly one grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_n_i | input | NCH | Sampled level of each request/grant line (low = pulse) |
| phase_i | input | 3 | Bus phase from sequencer: 0 idle, 1 T1, 2 T2, 3 T3, 4 wait, 5 T4 |
| odd_low_i | input | 1 | Current transfer is the low half of a word at an odd address |
| ack_first_i | input | 1 | Current transfer is the first interrupt acknowledge of a pair |
| lock_i | input | 1 | A locked instruction is executing |
| line_drv_o | output | NCH | Per-line drive enable; 1 pulls that line low (grant pulse) |
| bus_float_o | output | 1 | Command to float the local bus; an external master owns it |
| owner_o | output | NCH | One-hot marker of the line that currently owns the bus |

## Verification
The assertions take for granted that each external master pulses its line for exactly one clock. They also take for granted that a master keeps the line high for at least one clock between its own pulses, and that it never pulses its line during the clock the arbiter grants on it. They further assume that the sequencer reports idle while the bus is floated and steps through T1, T2, T3, any number of wait clocks and then T4. The random stimulus holds to these rules by construction: a requester waits two clocks after its previous pulse, holds back while its request is outstanding (except for rare repeat pulses placed outside grant clocks), and the phase generator forces idle whenever the bus is handed away.

// File: rtl/rg_pkg.sv
package rg_pkg;

   localparam int PH_W = 3;

   typedef enum logic [PH_W-1:0] {
      PH_IDLE = 3'd0,
      PH_T1   = 3'd1,
      PH_T2   = 3'd2,
      PH_T3   = 3'd3,
      PH_TW   = 3'd4,
      PH_T4   = 3'd5
   } bus_phase_e;

   typedef enum logic [1:0] {
      XS_OPEN = 2'd0,
      XS_HELD = 2'd1,
      XS_GAP  = 2'd2
   } xchg_e;

   function automatic logic phase_is_late(input bus_phase_e ph);
      return (ph == PH_T3) || (ph == PH_TW);
   endfunction

endpackage

// File: rtl/rg_pulse_detect.sv
module rg_pulse_detect #(
   parameter int NCH = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] line_n,
   input  logic [NCH-1:0] drv,
   output logic [NCH-1:0] evt
);

   logic [NCH-1:0] prev_hi;

   for (genvar i = 0; i < NCH; i++) begin : g_line
      // a low sample counts only when the line was released before and we are not pulling it now
      assign evt[i] = ~line_n[i] & prev_hi[i] & ~drv[i];

      always_ff @(posedge clk) begin
         if (!rst_n) prev_hi[i] <= 1'b1;
         else        prev_hi[i] <= line_n[i] | drv[i];
      end
   end

endmodule

// File: rtl/rg_pending.sv
module rg_pending
   import rg_pkg::*;
#(
   parameter int NCH = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] evt,
   input  logic [NCH-1:0] owner,
   input  logic           held,
   input  bus_phase_e     phase,
   input  logic [NCH-1:0] grant,
   output logic [NCH-1:0] pend,
   output logic [NCH-1:0] ready
);

   logic [NCH-1:0] late;
   logic [NCH-1:0] cap;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      // a pulse from the current owner is its release, not a new request
      assign cap[i]   = evt[i] & ~(held & owner[i]);
      assign ready[i] = pend[i] & ~late[i];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend[i] <= 1'b0;
            late[i] <= 1'b0;
         end else if (grant[i]) begin
            pend[i] <= 1'b0;
            late[i] <= 1'b0;
         end else if (cap[i] && !pend[i]) begin
            pend[i] <= 1'b1;
            late[i] <= phase_is_late(phase);
         end else if (phase == PH_T4) begin
            late[i] <= 1'b0;
         end
      end
   end

   // R7
   late_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & late) == '0);

endmodule

// File: rtl/rg_pick.sv
module rg_pick #(
   parameter int NCH = 2
) (
   input  logic [NCH-1:0] ready,
   output logic [NCH-1:0] pick
);

   always_comb begin
      pick = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (ready[i]) begin
            pick    = '0;
            pick[i] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/rg_release_gate.sv
module rg_release_gate
   import rg_pkg::*;
(
   input  bus_phase_e phase,
   input  logic       odd_low,
   input  logic       ack_first,
   input  logic       lock,
   output logic       ok
);

   logic idle_ok;
   logic t4_ok;

   assign idle_ok = (phase == PH_IDLE);
   assign t4_ok   = (phase == PH_T4) && !odd_low && !ack_first;
   assign ok      = !lock && (idle_ok || t4_ok);

endmodule

// File: rtl/rg_arbiter.sv
module rg_arbiter
   import rg_pkg::*;
#(
   parameter int NCH        = 2,
   parameter int GAP_CYCLES = 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] line_n_i,
   input  logic [2:0]     phase_i,
   input  logic           odd_low_i,
   input  logic           ack_first_i,
   input  logic           lock_i,
   output logic [NCH-1:0] line_drv_o,
   output logic           bus_float_o,
   output logic [NCH-1:0] owner_o
);

   localparam int GW = (GAP_CYCLES < 1) ? 1 : $clog2(GAP_CYCLES + 1);

   if (NCH < 1 || NCH > 8) begin : g_bad_nch
      $error("rg_arbiter: NCH must lie in 1..8");
   end
   if (GAP_CYCLES < 1) begin : g_bad_gap
      $error("rg_arbiter: at least one dead clock is required");
   end

   bus_phase_e     ph;
   xchg_e          state;
   logic [NCH-1:0] owner;
   logic [GW-1:0]  gap_cnt;
   logic [NCH-1:0] evt;
   logic [NCH-1:0] pend;
   logic [NCH-1:0] ready;
   logic [NCH-1:0] pick;
   logic [NCH-1:0] grant;
   logic           gate_ok;

   assign ph = bus_phase_e'(phase_i);

   rg_pulse_detect #(.NCH(NCH)) u_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_n (line_n_i),
      .drv    (grant),
      .evt    (evt)
   );

   rg_pending #(.NCH(NCH)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt),
      .owner  (owner),
      .held   (state == XS_HELD),
      .phase  (ph),
      .grant  (grant),
      .pend   (pend),
      .ready  (ready)
   );

   rg_pick #(.NCH(NCH)) u_pick (
      .ready (ready),
      .pick  (pick)
   );

   rg_release_gate u_gate (
      .phase     (ph),
      .odd_low   (odd_low_i),
      .ack_first (ack_first_i),
      .lock      (lock_i),
      .ok        (gate_ok)
   );

   assign grant = (state == XS_OPEN && gate_ok) ? pick : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= XS_OPEN;
         owner   <= '0;
         gap_cnt <= '0;
      end else begin
         unique case (state)
            XS_OPEN: begin
               if (|grant) begin
                  state <= XS_HELD;
                  owner <= grant;
               end
            end
            XS_HELD: begin
               if (|(evt & owner)) begin
                  state   <= XS_GAP;
                  owner   <= '0;
                  gap_cnt <= GW'(GAP_CYCLES - 1);
               end
            end
            XS_GAP: begin
               if (gap_cnt == '0) state <= XS_OPEN;
               else               gap_cnt <= gap_cnt - GW'(1);
            end
            default: state <= XS_OPEN;
         endcase
      end
   end

   assign line_drv_o  = grant;
   assign bus_float_o = (state == XS_HELD);
   assign owner_o     = owner;

   // R10
   one_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(line_drv_o));

   // R10
   no_drive_floated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_float_o |-> (line_drv_o == '0));

   // R3
   float_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|line_drv_o) |=> (bus_float_o && $onehot(owner_o)));

   // R3
   owner_while_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_float_o |-> $onehot(owner_o));

   // R4
   dead_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_float_o) |-> (line_drv_o == '0));

   // R6
   grant_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|line_drv_o) |-> (phase_i == 3'd0 || phase_i == 3'd5));

   // R8
   split_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_i == 3'd5 && (odd_low_i || ack_first_i)) |-> (line_drv_o == '0));

   // R9
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_i |-> (line_drv_o == '0));

   // R5
   grant_was_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((line_drv_o & ~pend) == '0));

endmodule

// File: tb/sim_rg_arbiter.sv
`timescale 1ns/100ps
module sim_rg_arbiter;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] ext_low;
   logic [2:0] phase;
   logic       odd, ack, lock;
   logic [1:0] line_n;
   logic [1:0] drv;
   logic       flt;
   logic [1:0] own;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit done  = 0;

   always #2.5 clk = ~clk;

   assign line_n = ~(drv | ext_low);

   rg_arbiter #(.NCH(2), .GAP_CYCLES(1)) u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_n_i    (line_n),
      .phase_i     (phase),
      .odd_low_i   (odd),
      .ack_first_i (ack),
      .lock_i      (lock),
      .line_drv_o  (drv),
      .bus_float_o (flt),
      .owner_o     (own)
   );

   // reference model built from the requirements
   logic [1:0] m_pend, m_late, m_own, m_prev_hi;
   int         m_st;

   function automatic logic [1:0] exp_drv();
      logic [1:0] rdy;
      if (m_st != 0 || lock) return 2'b00;
      if (!(phase == 3'd0 || (phase == 3'd5 && !odd && !ack))) return 2'b00;
      rdy = m_pend & ~m_late;
      if (rdy[0]) return 2'b01;
      if (rdy[1]) return 2'b10;
      return 2'b00;
   endfunction

   always @(posedge clk) begin
      logic [1:0] g, ev;
      cyc++;
      if (!rst_n) begin
         m_pend = 0; m_late = 0; m_own = 0; m_prev_hi = 2'b11; m_st = 0;
      end else begin
         g  = exp_drv();
         ev = ~line_n & m_prev_hi & ~g;
         m_prev_hi = line_n | g;
         for (int i = 0; i < 2; i++) begin
            if (g[i]) begin
               m_pend[i] = 0; m_late[i] = 0;
            end else if (ev[i] && !(m_st == 1 && m_own[i]) && !m_pend[i]) begin
               m_pend[i] = 1; m_late[i] = (phase == 3'd3 || phase == 3'd4);
            end else if (phase == 3'd5) begin
               m_late[i] = 0;
            end
         end
         case (m_st)
            0: if (g != 0) begin m_st = 1; m_own = g; end
            1: if ((ev & m_own) != 0) begin m_st = 2; m_own = 0; end
            default: m_st = 0;
         endcase
      end
   end

   task automatic chk(input string tag, input logic [1:0] got, input logic [1:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s at cycle %0d: actual=%b expected=%b", tag, cyc, got, exp);
      end
   endtask

   // apply one cycle of stimulus after the falling edge, compare before the rising edge
   task automatic step(input logic [1:0] e, input logic [2:0] ph,
                       input logic o, input logic a, input logic l);
      @(negedge clk);
      ext_low = e; phase = ph; odd = o; ack = a; lock = l;
      #1;
      chk("R10 drive vs model", drv, exp_drv());
      chk("R3 float vs model", {1'b0, flt}, {1'b0, (m_st == 1)});
      chk("R3 owner vs model", own, m_own);
   endtask

   task automatic idle(input logic [1:0] e);
      step(e, 3'd0, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      #1000000;
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [2:0] ph;
      logic [1:0] e;
      bit   [1:0] waiting;
      int         hold_cnt [2];
      int         hold_tgt [2];
      int         last [2];
      logic       lk;
      void'($urandom(32'd20240611));
      rst_n = 0; ext_low = 0; phase = 0; odd = 0; ack = 0; lock = 0;
      repeat (3) @(negedge clk);
      #1;
      chk("R1 reset drive", drv, 2'b00);
      chk("R1 reset float", {1'b0, flt}, 2'b00);
      chk("R1 reset owner", own, 2'b00);
      @(negedge clk); rst_n = 1;
      #1;
      chk("R1 first cycle drive", drv, 2'b00);

      // R2 / R3: idle grant on line 0
      idle(2'b01);  chk("R2 no drive in pulse clock", drv, 2'b00);
      idle(2'b00);  chk("R2 grant next clock", drv, 2'b01);
      idle(2'b00);  chk("R3 float after grant", {1'b0, flt}, 2'b01);
                    chk("R10 drive one clock", drv, 2'b00);
                    chk("R3 owner line 0", own, 2'b01);
      idle(2'b00);
      idle(2'b01);  chk("R3 float in release clock", {1'b0, flt}, 2'b01);
      idle(2'b00);  chk("R3 reclaimed", {1'b0, flt}, 2'b00);
      idle(2'b00);

      // R5 / R4 / R11: both request, line 0 wins, line 1 after dead clock
      idle(2'b11);
      idle(2'b00);  chk("R5 lower index first", drv, 2'b01);
      idle(2'b00);
      idle(2'b01);
      idle(2'b00);  chk("R4 dead clock no grant", drv, 2'b00);
      idle(2'b00);  chk("R5 second line served", drv, 2'b10);
      idle(2'b01);  chk("R3 owner line 1", own, 2'b10);
      idle(2'b00);
      idle(2'b01);  // repeat request while pending
      idle(2'b10);  // line 1 releases
      idle(2'b00);  chk("R4 dead clock after release", drv, 2'b00);
      idle(2'b00);  chk("R11 single grant line 0", drv, 2'b01);
      idle(2'b01);
      for (int k = 0; k < 4; k++) begin
         idle(2'b00); chk("R11 no extra grant", drv, 2'b00);
      end

      // R6: request in T1, grant only at T4
      step(2'b01, 3'd1, 0, 0, 0);
      step(2'b00, 3'd2, 0, 0, 0); chk("R6 no grant T2", drv, 2'b00);
      step(2'b00, 3'd3, 0, 0, 0); chk("R6 no grant T3", drv, 2'b00);
      step(2'b00, 3'd4, 0, 0, 0); chk("R6 no grant wait", drv, 2'b00);
      step(2'b00, 3'd5, 0, 0, 0); chk("R6 grant at T4", drv, 2'b01);
      idle(2'b00); idle(2'b01); idle(2'b00); idle(2'b00);

      // R7: request in T3 misses this T4
      step(2'b00, 3'd1, 0, 0, 0);
      step(2'b00, 3'd2, 0, 0, 0);
      step(2'b10, 3'd3, 0, 0, 0);
      step(2'b00, 3'd5, 0, 0, 0); chk("R7 late request skips T4", drv, 2'b00);
      step(2'b00, 3'd1, 0, 0, 0);
      step(2'b00, 3'd2, 0, 0, 0);
      step(2'b00, 3'd3, 0, 0, 0);
      step(2'b00, 3'd5, 0, 0, 0); chk("R7 granted next T4", drv, 2'b10);
      idle(2'b10); idle(2'b00); idle(2'b00);

      // R8: odd-address low half and first acknowledge block T4
      step(2'b01, 3'd1, 0, 0, 0);
      step(2'b00, 3'd2, 0, 0, 0);
      step(2'b00, 3'd3, 0, 0, 0);
      step(2'b00, 3'd5, 1, 0, 0); chk("R8 odd low half blocks", drv, 2'b00);
      step(2'b00, 3'd1, 0, 0, 0);
      step(2'b00, 3'd2, 0, 0, 0);
      step(2'b00, 3'd3, 0, 0, 0);
      step(2'b00, 3'd5, 0, 1, 0); chk("R8 first ack blocks", drv, 2'b00);
      step(2'b00, 3'd1, 0, 0, 0);
      step(2'b00, 3'd2, 0, 0, 0);
      step(2'b00, 3'd3, 0, 0, 0);
      step(2'b00, 3'd5, 0, 0, 0); chk("R8 plain T4 grants", drv, 2'b01);
      idle(2'b01); idle(2'b00); idle(2'b00);

      // R9: lock holds the bus
      step(2'b10, 3'd0, 0, 0, 1);
      for (int k = 0; k < 3; k++) begin
         step(2'b00, 3'd0, 0, 0, 1); chk("R9 lock blocks grant", drv, 2'b00);
      end
      idle(2'b00); chk("R9 grant after unlock", drv, 2'b10);
      idle(2'b10); idle(2'b00); idle(2'b00);

      // constrained random traffic against the model
      ph = 3'd0; lk = 0; waiting = 0;
      for (int i = 0; i < 2; i++) begin hold_cnt[i] = 0; hold_tgt[i] = 1; last[i] = -10; end
      for (int n = 0; n < 4000; n++) begin
         if (m_st == 1) ph = 3'd0;
         else begin
            case (ph)
               3'd0: ph = ($urandom % 100 < 35) ? 3'd1 : 3'd0;
               3'd1: ph = 3'd2;
               3'd2: ph = 3'd3;
               3'd3: ph = ($urandom % 4 == 0) ? 3'd4 : 3'd5;
               3'd4: ph = ($urandom % 2 == 0) ? 3'd4 : 3'd5;
               default: ph = ($urandom % 2 == 0) ? 3'd1 : 3'd0;
            endcase
         end
         if ($urandom % 100 < 3) lk = ~lk;
         e = 2'b00;
         for (int i = 0; i < 2; i++) begin
            if (m_own[i]) begin
               waiting[i] = 0;
               hold_cnt[i]++;
               if (hold_cnt[i] >= hold_tgt[i] && n - last[i] >= 2) begin
                  e[i] = 1; last[i] = n; hold_cnt[i] = 0;
                  hold_tgt[i] = 1 + int'($urandom % 6);
               end
            end else if (n - last[i] >= 2) begin
               if (!waiting[i] && $urandom % 8 == 0) begin
                  e[i] = 1; waiting[i] = 1; last[i] = n;
               end else if (waiting[i] && $urandom % 50 == 0 && m_st != 0) begin
                  e[i] = 1; last[i] = n;  // R11 repeat pulse outside grant clocks
               end
            end
         end
         step(e, ph, ($urandom % 4 == 0), ($urandom % 4 == 0), lk);
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule